// File: doc/BRIEF.md
# Hop-Indexed Mesh Latency Predictor

This block sits in each node of a packet-switched mesh and estimates how many cycles a packet will spend in transit for a given hop count. It keeps a short history of measured latencies for each hop count. When a predict request arrives, it returns the estimate from whichever of three estimation strategies has recently been the most accurate.

Measured latencies come in on a feedback port, tagged with the hop count they belong to. Each feedback sample is first used to score the three strategies against what they would have predicted for that hop count. The sample is then pushed into the history row for that hop count. Two strategies average the history and one tracks the newest value, so the block can follow fast changes in congestion or smooth out single spikes, depending on which has been working better.

Top module: `mesh_lat_predictor`

## Requirements
- R1: After reset every history slot and every accuracy counter is 0, `pred_out_valid` is low and `pred_latency` is 0.
- R2: A request with `pred_valid` high and `pred_hops` in 0..13 gives `pred_out_valid` high in the next cycle. In that same cycle `pred_latency` holds the estimate for row `pred_hops`. `pred_out_valid` is low in every cycle that does not follow a request.
- R3: A measured latency of 255 or more is stored as 255.
- R4: Each row holds the four most recent stored samples, newest first. Strategy A (code 0) returns the newest sample. Strategy B (code 1) returns the floor of the mean of the two newest samples. Strategy C (code 2) returns the floor of the mean of all four samples.
- R5: On a valid update with `upd_hops` in 0..13, the winning strategy's 4-bit counter adds 2 and saturates at 15. Each other strategy's counter subtracts 1 and saturates at 0. The winner is the strategy whose prediction for that row, taken before the sample is inserted, is closest in absolute difference to the stored (clamped) sample. Ties go to A, then B, then C. Counters change only on such updates.
- R6: A prediction uses the strategy with the highest counter, with ties resolved A, then B, then C. The code of the chosen strategy appears on `pred_strategy` alongside `pred_latency`.
- R7: When a predict and an update occur in the same cycle, the prediction uses the history and counters as they were before that update.
- R8: An update with `upd_hops` of 14 or more changes neither any row nor any counter. A predict with `pred_hops` of 14 or more returns latency 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Predict request |
| pred_hops | input | 4 | Hop count to predict for |
| upd_valid | input | 1 | Measured-latency feedback |
| upd_hops | input | 4 | Hop count of the measured packet |
| upd_latency | input | 12 | Measured latency in cycles |
| pred_out_valid | output | 1 | Prediction result valid |
| pred_latency | output | 8 | Predicted latency |
| pred_strategy | output | 2 | Strategy used: 0 newest, 1 mean of two, 2 mean of four |

## Verification
The hardest state to reach is one where the four-sample mean leads the counters. Starting from reset, A wins every tie, so C only takes the lead after a series of updates in which the long average is strictly closer than both the newest sample and the two-sample mean. A directed sequence on one row (100, then 20, then 30) reaches this state in three updates. A second directed step feeds a 600-cycle sample and checks the clamp through the resulting mean. After that, a long mixed run of predicts and updates, some to hop counts beyond the table and some in the same cycle, is compared against a reference model of the requirements.

// File: rtl/mesh_lat_predictor.sv
module mesh_lat_predictor #(
  parameter int HOPS  = 14,
  parameter int W     = 8,
  parameter int IN_W  = 12,
  parameter int CW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pred_valid,
  input  logic [3:0]      pred_hops,
  input  logic            upd_valid,
  input  logic [3:0]      upd_hops,
  input  logic [IN_W-1:0] upd_latency,
  output logic            pred_out_valid,
  output logic [W-1:0]    pred_latency,
  output logic [1:0]      pred_strategy
);
  localparam int DEPTH = 4;
  localparam logic [W-1:0]  LMAX = {W{1'b1}};
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [W-1:0]  hist [HOPS][DEPTH];
  logic [CW-1:0] cnt  [3];

  function automatic logic [W-1:0] est(input logic [W-1:0] r0, r1, r2, r3, input logic [1:0] s);
    logic [W:0]   s2;
    logic [W+1:0] s4;
    s2 = {1'b0, r0} + {1'b0, r1};
    s4 = {2'b0, r0} + {2'b0, r1} + {2'b0, r2} + {2'b0, r3};
    case (s)
      2'd0:    est = r0;
      2'd1:    est = s2[W:1];
      default: est = s4[W+1:2];
    endcase
  endfunction

  function automatic logic [W-1:0] adiff(input logic [W-1:0] a, b);
    adiff = (a > b) ? a - b : b - a;
  endfunction

  logic          p_in, u_in;
  logic [3:0]    p_row, u_row;
  logic [1:0]    sel, win;
  logic [W-1:0]  act, ea, eb, ec;

  assign p_in  = pred_hops < 4'(HOPS);
  assign u_in  = upd_hops  < 4'(HOPS);
  assign p_row = p_in ? pred_hops : 4'd0;
  assign u_row = u_in ? upd_hops  : 4'd0;
  assign act   = (upd_latency >= IN_W'(LMAX)) ? LMAX : upd_latency[W-1:0];

  assign sel = (cnt[0] >= cnt[1] && cnt[0] >= cnt[2]) ? 2'd0 :
               (cnt[1] >= cnt[2]) ? 2'd1 : 2'd2;

  assign ea = adiff(est(hist[u_row][0], hist[u_row][1], hist[u_row][2], hist[u_row][3], 2'd0), act);
  assign eb = adiff(est(hist[u_row][0], hist[u_row][1], hist[u_row][2], hist[u_row][3], 2'd1), act);
  assign ec = adiff(est(hist[u_row][0], hist[u_row][1], hist[u_row][2], hist[u_row][3], 2'd2), act);

  assign win = (ea <= eb && ea <= ec) ? 2'd0 : (eb <= ec) ? 2'd1 : 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_out_valid <= 1'b0;
      pred_latency   <= '0;
      pred_strategy  <= 2'd0;
    end else begin
      pred_out_valid <= pred_valid;
      if (pred_valid) begin
        pred_strategy <= sel;
        pred_latency  <= p_in ? est(hist[p_row][0], hist[p_row][1], hist[p_row][2], hist[p_row][3], sel) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int h = 0; h < HOPS; h++)
        for (int d = 0; d < DEPTH; d++) hist[h][d] <= '0;
    end else if (upd_valid && u_in) begin
      hist[u_row][0] <= act;
      for (int d = 1; d < DEPTH; d++) hist[u_row][d] <= hist[u_row][d-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 3; s++) cnt[s] <= '0;
    end else if (upd_valid && u_in) begin
      for (int s = 0; s < 3; s++) begin
        if (win == 2'(s)) cnt[s] <= (cnt[s] > CMAX - CW'(2)) ? CMAX : cnt[s] + CW'(2);
        else              cnt[s] <= (cnt[s] == '0) ? '0 : cnt[s] - CW'(1);
      end
    end
  end

  AST_REQ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |=> pred_out_valid);  // R2
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |=> !pred_out_valid);  // R2
  AST_STRATEGY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    pred_out_valid |-> pred_strategy != 2'd3);  // R6
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_hops >= 4'(HOPS)) |=> pred_latency == '0);  // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_hops < 4'(HOPS)) |=> ($stable(cnt[0]) && $stable(cnt[1]) && $stable(cnt[2])));  // R5
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_hops < 4'(HOPS)) |=>
      $countones({cnt[0] > $past(cnt[0]) || $past(cnt[0]) == CMAX,
                  cnt[1] > $past(cnt[1]) || $past(cnt[1]) == CMAX,
                  cnt[2] > $past(cnt[2]) || $past(cnt[2]) == CMAX}) >= 1);  // R5
endmodule

// File: tb/test_mesh_lat_predictor.sv
`timescale 1ns/1ps
module test_mesh_lat_predictor;
  logic clk = 0, rst_n = 0;
  logic pred_valid = 0, upd_valid = 0;
  logic [3:0] pred_hops = 0, upd_hops = 0;
  logic [11:0] upd_latency = 0;
  logic pred_out_valid;
  logic [7:0] pred_latency;
  logic [1:0] pred_strategy;

  mesh_lat_predictor i_mesh_lat_predictor (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int q_lat[$], q_st[$];
  string q_tag[$];
  int mh[14][4];
  int mc[3];

  function automatic int mpred(int h, int s);
    if (h >= 14) return 0;
    case (s)
      0: return mh[h][0];
      1: return (mh[h][0] + mh[h][1]) / 2;
      default: return (mh[h][0] + mh[h][1] + mh[h][2] + mh[h][3]) / 4;
    endcase
  endfunction

  function automatic int msel();
    if (mc[0] >= mc[1] && mc[0] >= mc[2]) return 0;
    if (mc[1] >= mc[2]) return 1;
    return 2;
  endfunction

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit pv, int ph, bit uv, int uh, int ul, string tag);
    @(negedge clk);
    pred_valid = pv; pred_hops = 4'(ph);
    upd_valid = uv; upd_hops = 4'(uh); upd_latency = 12'(ul);
    if (pv) begin
      q_lat.push_back(mpred(ph, msel()));
      q_st.push_back(msel());
      q_tag.push_back(tag);
    end
    if (uv && uh < 14) begin
      int a, e0, e1, e2, w;
      a = ul > 255 ? 255 : ul;
      e0 = iabs(mpred(uh, 0) - a);
      e1 = iabs(mpred(uh, 1) - a);
      e2 = iabs(mpred(uh, 2) - a);
      w = (e0 <= e1 && e0 <= e2) ? 0 : (e1 <= e2) ? 1 : 2;
      for (int s = 0; s < 3; s++)
        mc[s] = (s == w) ? ((mc[s] + 2 > 15) ? 15 : mc[s] + 2) : ((mc[s] == 0) ? 0 : mc[s] - 1);
      for (int d = 3; d > 0; d--) mh[uh][d] = mh[uh][d-1];
      mh[uh][0] = a;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pred_out_valid) begin
      if (q_lat.size() == 0) check(0, "R2 unexpected result", 1, 0);
      else begin
        int el, es;
        string t;
        el = q_lat.pop_front(); es = q_st.pop_front(); t = q_tag.pop_front();
        check(pred_latency == 8'(el), {t, " latency"}, pred_latency, el);
        check(pred_strategy == 2'(es), {t, " strategy"}, pred_strategy, es);
      end
    end
  end

  initial begin
    #2000000;
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (mh[h, d]) mh[h][d] = 0;
    foreach (mc[s]) mc[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(pred_out_valid == 0, "R1 valid after reset", pred_out_valid, 0);
    check(pred_latency == 0, "R1 latency after reset", pred_latency, 0);
    cyc(1, 3, 0, 0, 0, "R1 empty row");
    // C reaches the lead on row 7
    cyc(0, 0, 1, 7, 100, "");
    cyc(0, 0, 1, 7, 20, "");
    cyc(0, 0, 1, 7, 30, "");
    cyc(1, 7, 0, 0, 0, "R4 R6 mean of four leads");
    cyc(0, 0, 0, 0, 0, "");
    check(pred_latency == 37, "R4 hand value", pred_latency, 37);
    check(pred_strategy == 2, "R6 hand strategy", pred_strategy, 2);
    // clamp
    cyc(0, 0, 1, 3, 600, "");
    cyc(1, 3, 0, 0, 0, "R3 clamped sample");
    cyc(0, 0, 0, 0, 0, "");
    check(pred_latency == 63, "R3 hand value", pred_latency, 63);
    // saturation
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 1, 9, "");
    cyc(1, 1, 0, 0, 0, "R5 saturated lead");
    // out of range
    cyc(0, 0, 1, 15, 200, "");
    cyc(1, 15, 0, 0, 0, "R8 out of range predict");
    cyc(1, 1, 0, 0, 0, "R8 ignored update");
    // same-cycle predict and update
    cyc(1, 1, 1, 1, 90, "R7 same cycle");
    cyc(1, 1, 0, 0, 0, "R7 after update");
    // mixed run
    for (int i = 0; i < 600; i++) begin
      int h, l;
      h = $urandom % 16;
      l = h * 6 + ($urandom % 40);
      if ($urandom % 10 == 0) l = 200 + ($urandom % 300);
      cyc($urandom % 2, $urandom % 16, $urandom % 3 != 0, h, l, "R2 R4 R5 R6 mixed");
    end
    cyc(0, 0, 0, 0, 0, "");
    repeat (3) @(negedge clk);
    check(q_lat.size() == 0, "R2 missing results", q_lat.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule